// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Monitor

This block runs an external temperature-sensor converter in automatic mode without software in the loop. While automatic mode is on, a period counter starts a scan every programmed number of clocks. A scan asks the converter for one sample per channel, lowest channel first, and keeps the latest code of each channel in a readable register. Codes rise with temperature. A selectable inversion reports a programmable maximum minus the raw code instead.

Each channel's code is compared with two thresholds. The alarm threshold feeds a level interrupt. The shutdown threshold feeds a latched shutdown signal, which is routed per channel to a GPIO-side output and/or a reset-unit-side output, with a selectable active level. Each condition has its own debounce count of consecutive over-threshold samples. When any channel's latest code is at or above its alarm threshold, the scan period switches to a second, usually shorter, value. Software reaches all of this through a simple word-addressed register bus. Reads are combinational and writes take effect at the next clock edge.

Top module: `tmon_ctrl`

## Requirements
- R1: After reset the control word at 0x004 reads 0, both period registers (0x154 normal, 0x158 high-temperature) read 3000, both debounce registers (0x14c alarm, 0x150 shutdown) read 4, the maximum-code register at 0x210 reads 2047, every threshold is 0xfff, and `irq` is 0. Both shutdown outputs sit at their inactive level, which is 1.
- R2: The control word (0x004), the shutdown-source enables (0x00c), the alarm enables (0x014), the GPIO routing (0x018) and the reset-unit routing (0x01c) are write-masked. A write changes lower bit n only when bit n+16 of the same write is 1.
- R3: When control bit 0 (automatic mode) is 0, `adc_req` stays low, and the period counter and the debounce counters are held at zero.
- R4: With automatic mode on, a scan starts every normal-period clocks. It requests channels 0, 1, … in ascending order, holding `adc_req` and `adc_chan` until `adc_valid` answers.
- R5: The code of channel c reads at 0x02c+4·c, zero-extended from 12 bits. With inversion off, it equals the raw sample.
- R6: With control bit 1 set, the stored code is the value at 0x210 minus the raw sample.
- R7: A channel meets a condition when its code is greater than or equal to the threshold (alarm at 0x06c+4·c, shutdown at 0x10c+4·c). The condition counts only after that many consecutive meeting samples, where a count of 0 acts as 1. A sample below the threshold restarts the count.
- R8: Alarm pending bit c (0x024) is set by a debounced alarm whatever the enable. `irq` is high exactly when some pending bit has its enable bit set.
- R9: While any channel's latest code is at or above its alarm threshold, scans start every high-temperature-period clocks instead.
- R10: Writing 1 to a pending bit clears it. A set in the same cycle wins over the clear, and a condition that persists sets the bit again on its next sample.
- R11: Shutdown pending bit c (0x028) is set by a debounced shutdown only when source enable bit c is set. It stays set until cleared, and drives the GPIO output when routing bit c at 0x018 is set and the reset-unit output when bit c at 0x01c is set.
- R12: Control bit 8 selects the shutdown active level (1 = active high). An output with no routed pending bit drives the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| adc_req | output | 1 | Sample request to the converter |
| adc_chan | output | CHW | Channel being requested |
| adc_valid | input | 1 | Converter answers with a sample |
| adc_data | input | 12 | Raw sample code |
| irq | output | 1 | Alarm interrupt (level) |
| shut_gpio | output | 1 | Shutdown toward the GPIO path |
| shut_rst | output | 1 | Shutdown toward the reset unit |

## Verification
Two events can land on the same clock edge: a software write-1-to-clear of an alarm pending bit, and a debounced over-threshold sample that sets that same bit. The bench's converter model drives the clearing write in the very negedge in which it presents the channel-0 sample, so both reach the edge together. The pending register is then read back and must still hold the bit. A separate clear, issued once the code has dropped below the threshold, must return the bit to 0 and take `irq` low, which shows that the clearing path itself works.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    // register offsets (byte addresses)
    localparam logic [11:0] A_CTRL = 12'h004;
    localparam logic [11:0] A_SDEN = 12'h00c;
    localparam logic [11:0] A_ALEN = 12'h014;
    localparam logic [11:0] A_GPIO = 12'h018;
    localparam logic [11:0] A_RSTU = 12'h01c;
    localparam logic [11:0] A_ALPD = 12'h024;
    localparam logic [11:0] A_SDPD = 12'h028;
    localparam logic [11:0] A_DATA = 12'h02c;
    localparam logic [11:0] A_ALTH = 12'h06c;
    localparam logic [11:0] A_SDTH = 12'h10c;
    localparam logic [11:0] A_ALDB = 12'h14c;
    localparam logic [11:0] A_SDDB = 12'h150;
    localparam logic [11:0] A_PNRM = 12'h154;
    localparam logic [11:0] A_PHOT = 12'h158;
    localparam logic [11:0] A_QMAX = 12'h210;

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SCAN = 1'b1} seq_st_e;

    // upper half of the write selects which lower bits take the new value
    function automatic logic [15:0] hw_merge(input logic [15:0] cur, input logic [31:0] wd);
        return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    endfunction

endpackage

// File: rtl/tmon_seq.sv
module tmon_seq import tmon_pkg::*; #(
    parameter int NCH = 2,
    parameter int CHW = 1,
    parameter int PW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           hot,
    input  logic [PW-1:0]  per_norm,
    input  logic [PW-1:0]  per_hot,
    input  logic           adc_valid,
    output logic           adc_req,
    output logic [CHW-1:0] adc_chan,
    output logic           smp_valid
);
    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    typedef struct packed {
        seq_st_e        st;
        logic [CHW-1:0] ch;
        logic [PW-1:0]  cnt;
    } seq_t;

    seq_t q, d;
    logic [PW:0] cnt_inc;
    logic [PW-1:0] per;
    logic expire;

    always_comb begin
        d       = q;
        per     = hot ? per_hot : per_norm;
        cnt_inc = {1'b0, q.cnt} + (PW+1)'(1);
        expire  = cnt_inc >= {1'b0, per};
        if (!run) begin
            d.st  = SEQ_IDLE;
            d.ch  = '0;
            d.cnt = '0;
        end else begin
            d.cnt = expire ? '0 : cnt_inc[PW-1:0];
            if (q.st == SEQ_SCAN && adc_valid) begin
                if (q.ch == LAST) begin
                    d.st = SEQ_IDLE;
                    d.ch = '0;
                end else begin
                    d.ch = q.ch + CHW'(1);
                end
            end
            if (q.st == SEQ_IDLE && expire) begin
                d.st = SEQ_SCAN;
                d.ch = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= SEQ_IDLE;
            q.ch  <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign adc_req   = (q.st == SEQ_SCAN);
    assign adc_chan  = q.ch;
    assign smp_valid = adc_req && adc_valid;

endmodule

// File: rtl/tmon_chan.sv
module tmon_chan #(
    parameter int DW = 12,
    parameter int QW = 11,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          smp,
    input  logic [DW-1:0] raw,
    input  logic          inv,
    input  logic [QW-1:0] qmax,
    input  logic [DW-1:0] th_al,
    input  logic [DW-1:0] th_sd,
    input  logic [BW-1:0] db_al,
    input  logic [BW-1:0] db_sd,
    output logic [DW-1:0] code,
    output logic          hot,
    output logic          al_hit,
    output logic          sd_hit
);
    typedef struct packed {
        logic [DW-1:0] code;
        logic          hot;
        logic [BW-1:0] cal;
        logic [BW-1:0] csd;
    } chan_t;

    chan_t q, d;
    logic [DW-1:0] smp_code;
    logic over_al, over_sd;
    logic [BW-1:0] need_al, need_sd, n_al, n_sd;

    always_comb begin
        d        = q;
        smp_code = inv ? (DW'(qmax) - raw) : raw;
        over_al  = smp_code >= th_al;
        over_sd  = smp_code >= th_sd;
        need_al  = (db_al == '0) ? BW'(1) : db_al;
        need_sd  = (db_sd == '0) ? BW'(1) : db_sd;
        n_al     = !over_al ? '0 : ((q.cal >= need_al) ? q.cal : q.cal + BW'(1));
        n_sd     = !over_sd ? '0 : ((q.csd >= need_sd) ? q.csd : q.csd + BW'(1));
        al_hit   = run && smp && over_al && (n_al >= need_al);
        sd_hit   = run && smp && over_sd && (n_sd >= need_sd);
        if (!run) begin
            d.hot = 1'b0;
            d.cal = '0;
            d.csd = '0;
        end else if (smp) begin
            d.code = smp_code;
            d.hot  = over_al;
            d.cal  = n_al;
            d.csd  = n_sd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code = q.code;
    assign hot  = q.hot;

endmodule

// File: rtl/tmon_ctrl.sv
module tmon_ctrl import tmon_pkg::*; #(
    parameter int NCH     = 2,
    parameter int DW      = 12,
    parameter int QW      = 11,
    parameter int PW      = 16,
    parameter int BW      = 8,
    parameter int DEF_PER = 3000,
    parameter int DEF_DB  = 4,
    parameter int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [11:0]    bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           adc_req,
    output logic [CHW-1:0] adc_chan,
    input  logic           adc_valid,
    input  logic [DW-1:0]  adc_data,
    output logic           irq,
    output logic           shut_gpio,
    output logic           shut_rst
);
    typedef struct packed {
        logic [15:0]            ctrl;
        logic [NCH-1:0]         sden, alen, gpio, rstu, alpd, sdpd;
        logic [NCH-1:0][DW-1:0] thal, thsd;
        logic [BW-1:0]          dbal, dbsd;
        logic [PW-1:0]          pnrm, phot;
        logic [QW-1:0]          qmax;
    } regs_t;

    regs_t q, d;
    logic [NCH-1:0]         al_hit, sd_hit, hot;
    logic [NCH-1:0][DW-1:0] code;
    logic                   smp_v;
    logic                   run_w, inv_w, pol_w, act_g, act_r;
    logic [NCH-1:0]         alpd_w, sdpd_w, gpio_w;

    assign run_w  = q.ctrl[0];
    assign inv_w  = q.ctrl[1];
    assign pol_w  = q.ctrl[8];
    assign alpd_w = q.alpd;
    assign sdpd_w = q.sdpd;
    assign gpio_w = q.gpio;

    tmon_seq #(.NCH(NCH), .CHW(CHW), .PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run_w), .hot(|hot),
        .per_norm(q.pnrm), .per_hot(q.phot), .adc_valid(adc_valid),
        .adc_req(adc_req), .adc_chan(adc_chan), .smp_valid(smp_v)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmon_chan #(.DW(DW), .QW(QW), .BW(BW)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run_w),
            .smp(smp_v && (adc_chan == CHW'(c))), .raw(adc_data),
            .inv(inv_w), .qmax(q.qmax), .th_al(q.thal[c]), .th_sd(q.thsd[c]),
            .db_al(q.dbal), .db_sd(q.dbsd), .code(code[c]), .hot(hot[c]),
            .al_hit(al_hit[c]), .sd_hit(sd_hit[c])
        );
    end

    // next register state: bus writes first, hardware sets last so they win
    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: d.ctrl = hw_merge(q.ctrl, bus_wdata) & 16'h0103;
                A_SDEN: d.sden = NCH'(hw_merge(16'(q.sden), bus_wdata));
                A_ALEN: d.alen = NCH'(hw_merge(16'(q.alen), bus_wdata));
                A_GPIO: d.gpio = NCH'(hw_merge(16'(q.gpio), bus_wdata));
                A_RSTU: d.rstu = NCH'(hw_merge(16'(q.rstu), bus_wdata));
                A_ALPD: d.alpd = q.alpd & ~bus_wdata[NCH-1:0];
                A_SDPD: d.sdpd = q.sdpd & ~bus_wdata[NCH-1:0];
                A_ALDB: d.dbal = bus_wdata[BW-1:0];
                A_SDDB: d.dbsd = bus_wdata[BW-1:0];
                A_PNRM: d.pnrm = bus_wdata[PW-1:0];
                A_PHOT: d.phot = bus_wdata[PW-1:0];
                A_QMAX: d.qmax = bus_wdata[QW-1:0];
                default: ;
            endcase
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == A_ALTH + 12'(4*c)) d.thal[c] = bus_wdata[DW-1:0];
                if (bus_addr == A_SDTH + 12'(4*c)) d.thsd[c] = bus_wdata[DW-1:0];
            end
        end
        d.alpd = d.alpd | al_hit;
        d.sdpd = d.sdpd | (sd_hit & q.sden);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.thal <= '1;
            q.thsd <= '1;
            q.dbal <= BW'(DEF_DB);
            q.dbsd <= BW'(DEF_DB);
            q.pnrm <= PW'(DEF_PER);
            q.phot <= PW'(DEF_PER);
            q.qmax <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = 32'(q.ctrl);
            A_SDEN: bus_rdata = 32'(q.sden);
            A_ALEN: bus_rdata = 32'(q.alen);
            A_GPIO: bus_rdata = 32'(q.gpio);
            A_RSTU: bus_rdata = 32'(q.rstu);
            A_ALPD: bus_rdata = 32'(q.alpd);
            A_SDPD: bus_rdata = 32'(q.sdpd);
            A_ALDB: bus_rdata = 32'(q.dbal);
            A_SDDB: bus_rdata = 32'(q.dbsd);
            A_PNRM: bus_rdata = 32'(q.pnrm);
            A_PHOT: bus_rdata = 32'(q.phot);
            A_QMAX: bus_rdata = 32'(q.qmax);
            default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == A_DATA + 12'(4*c)) bus_rdata = 32'(code[c]);
            if (bus_addr == A_ALTH + 12'(4*c)) bus_rdata = 32'(q.thal[c]);
            if (bus_addr == A_SDTH + 12'(4*c)) bus_rdata = 32'(q.thsd[c]);
        end
    end

    assign irq       = |(q.alpd & q.alen);
    assign act_g     = |(q.sdpd & q.gpio);
    assign act_r     = |(q.sdpd & q.rstu);
    assign shut_gpio = pol_w ? act_g : ~act_g;
    assign shut_rst  = pol_w ? act_r : ~act_r;

endmodule

// File: rtl/tmon_ctrl_chk.sv
module tmon_ctrl_chk #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [11:0]    bus_addr,
    input logic           adc_req,
    input logic [CHW-1:0] adc_chan,
    input logic           adc_valid,
    input logic           run_w,
    input logic           pol_w,
    input logic [NCH-1:0] alpd_w,
    input logic [NCH-1:0] sdpd_w,
    input logic [NCH-1:0] gpio_w,
    input logic           shut_gpio
);
    p_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !adc_req);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_valid && run_w) |=> (adc_req && $stable(adc_chan)));

    p_chan_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && $past(adc_req) && (adc_chan != $past(adc_chan)))
        |-> (adc_chan == CHW'($past(adc_chan) + 1'b1)));

    p_pend_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((alpd_w & ~$past(alpd_w)) != '0) |-> $past(adc_req && adc_valid));

    p_shut_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sdpd_w & ~$past(sdpd_w)) == '0 && (~sdpd_w & $past(sdpd_w)) != '0)
        |-> $past(bus_wr && bus_addr == 12'h028));

    p_shut_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sdpd_w) && $stable(pol_w) && $stable(gpio_w)) |-> $stable(shut_gpio));

endmodule

bind tmon_ctrl tmon_ctrl_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_valid(adc_valid),
    .run_w(run_w), .pol_w(pol_w), .alpd_w(alpd_w), .sdpd_w(sdpd_w),
    .gpio_w(gpio_w), .shut_gpio(shut_gpio)
);

// File: tb/tmon_ctrl_tb_top.sv
module tmon_ctrl_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_wr = 1'b0;
    logic [11:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        cv_ack = 1'b0;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        adc_req;
    logic [0:0]  adc_chan;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_data = '0;
    logic        irq, shut_gpio, shut_rst;

    logic [11:0] raw_tab [2];
    int served [2];
    int exp_q [$];
    int nvec = 0, nerr = 0, cyc = 0, nstart = 0, last_start = 0, prev_start = 0;
    bit ack_arm = 0, req_prev = 0, done = 0;
    logic [31:0] rv;

    // the converter model may inject a pending-clear write
    assign bus_wr    = m_wr | cv_ack;
    assign bus_addr  = cv_ack ? 12'h024 : m_addr;
    assign bus_wdata = cv_ack ? 32'h1 : m_wdata;

    tmon_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_req(adc_req),
        .adc_chan(adc_chan), .adc_valid(adc_valid), .adc_data(adc_data),
        .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model and scoreboard monitor
    always @(negedge clk) begin
        cv_ack = 1'b0;
        if (adc_req && !req_prev) begin
            prev_start = last_start;
            last_start = cyc;
            nstart++;
        end
        req_prev = adc_req;
        if (adc_valid) begin
            adc_valid = 1'b0;
        end else if (adc_req) begin
            adc_valid = 1'b1;
            adc_data  = raw_tab[adc_chan];
            if (exp_q.size() > 0) chk("R4 scan order", 32'(adc_chan), 32'(exp_q.pop_front()));
            if (ack_arm && adc_chan == 1'b0) begin
                cv_ack  = 1'b1;
                ack_arm = 0;
            end
            served[adc_chan]++;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        m_wr = 1'b1; m_addr = a; m_wdata = v;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        m_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic sync0();
        int s = served[0];
        while (served[0] == s) @(negedge clk);
    endtask

    task automatic wait0(input int n);
        int s = served[0];
        while (served[0] < s + n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic push_scan();
        for (int c = 0; c < 2; c++) exp_q.push_back(c);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        raw_tab[0] = 12'd100; raw_tab[1] = 12'd200;
        served[0] = 0; served[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h004, rv); chk("R1 ctrl", rv, 0);
        rd(12'h154, rv); chk("R1 normal period", rv, 3000);
        rd(12'h158, rv); chk("R1 hot period", rv, 3000);
        rd(12'h14c, rv); chk("R1 alarm debounce", rv, 4);
        rd(12'h150, rv); chk("R1 shut debounce", rv, 4);
        rd(12'h210, rv); chk("R1 max code", rv, 2047);
        rd(12'h06c, rv); chk("R1 alarm threshold", rv, 12'hfff);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 shut_gpio", 32'(shut_gpio), 1);
        chk("R1 shut_rst", 32'(shut_rst), 1);
        // R2 masked write has no effect
        wr(12'h004, 32'h0000_0001);
        rd(12'h004, rv); chk("R2 unmasked write ignored", rv, 0);
        // R3 automatic mode off: no requests
        repeat (50) @(negedge clk);
        chk("R3 no request while off", 32'(nstart), 0);
        // R4/R5 normal scanning
        wr(12'h154, 16); wr(12'h158, 10);
        push_scan(); push_scan(); push_scan();
        wr(12'h004, 32'h0001_0001);
        rd(12'h004, rv); chk("R2 masked set", rv, 1);
        while (nstart < 3) @(negedge clk);
        chk("R4 normal period", 32'(last_start - prev_start), 16);
        repeat (8) @(negedge clk);
        rd(12'h02c, rv); chk("R5 data ch0", rv, 100);
        rd(12'h030, rv); chk("R5 data ch1", rv, 200);
        // R6 inversion
        wr(12'h004, 32'h0002_0002);
        rd(12'h004, rv); chk("R2 bit0 held", rv, 3);
        wait0(2);
        rd(12'h02c, rv); chk("R6 inverted ch0", rv, 1947);
        rd(12'h030, rv); chk("R6 inverted ch1", rv, 1847);
        wr(12'h004, 32'h0002_0000);
        // R7 alarm debounce
        wr(12'h14c, 3); wr(12'h06c, 500);
        wait0(1);
        sync0();
        raw_tab[0] = 12'd600;
        wait0(2);
        rd(12'h024, rv); chk("R7 two samples not enough", rv, 0);
        wait0(1);
        rd(12'h024, rv); chk("R7 third sample sets", rv, 1);
        chk("R8 irq masked by enable", 32'(irq), 0);
        wr(12'h014, 32'h0001_0001);
        chk("R8 irq with enable", 32'(irq), 1);
        // R9 hot period
        n = nstart;
        while (nstart < n + 3) @(negedge clk);
        chk("R9 hot period", 32'(last_start - prev_start), 10);
        // R10 clear, re-set, and clear colliding with set
        sync0();
        wr(12'h024, 1);
        rd(12'h024, rv); chk("R10 clear", rv, 0);
        wait0(1);
        rd(12'h024, rv); chk("R10 persistent re-set", rv, 1);
        ack_arm = 1;
        wait0(1);
        rd(12'h024, rv); chk("R10 set wins over clear", rv, 1);
        raw_tab[0] = 12'd100;
        wait0(1);
        wr(12'h024, 1);
        rd(12'h024, rv); chk("R10 clear when cool", rv, 0);
        chk("R8 irq low after clear", 32'(irq), 0);
        // R11 shutdown to GPIO path
        wr(12'h10c, 700); wr(12'h150, 2);
        wr(12'h00c, 32'h0001_0001); wr(12'h018, 32'h0001_0001);
        sync0();
        raw_tab[0] = 12'd800;
        wait0(1);
        chk("R11 debounce holds shut", 32'(shut_gpio), 1);
        wait0(1);
        chk("R11 shut gpio active low", 32'(shut_gpio), 0);
        chk("R11 reset path not routed", 32'(shut_rst), 1);
        rd(12'h028, rv); chk("R11 shut pending", rv, 1);
        raw_tab[0] = 12'd100;
        wait0(1);
        chk("R11 shut latched", 32'(shut_gpio), 0);
        // R12 polarity
        wr(12'h004, 32'h0100_0100);
        chk("R12 active high", 32'(shut_gpio), 1);
        chk("R12 inactive low", 32'(shut_rst), 0);
        wr(12'h028, 1);
        chk("R12 cleared drives inactive", 32'(shut_gpio), 0);
        // R11 reset-unit routing, count restarted by cool samples (R7)
        wr(12'h018, 32'h0001_0000); wr(12'h01c, 32'h0001_0001);
        sync0();
        raw_tab[0] = 12'd800;
        wait0(1);
        chk("R7 count restarted after cool sample", 32'(shut_rst), 0);
        wait0(1);
        chk("R11 reset path active", 32'(shut_rst), 1);
        chk("R11 gpio unrouted", 32'(shut_gpio), 0);
        // R3 disable stops scanning
        wr(12'h004, 32'h0001_0000);
        repeat (3) @(negedge clk);
        n = nstart;
        repeat (60) @(negedge clk);
        chk("R3 no scans after disable", 32'(nstart), 32'(n));
        chk("R3 request low", 32'(adc_req), 0);
        finish_run();
    end

endmodule